// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between an on-chip requester and an external byte-wide asynchronous static RAM of 128K locations. Each accepted request is a single read or a single write. The block turns it into a timed sequence on the RAM's control pins: a low-true select, a high-true select, a low-true write strobe and a low-true output strobe, plus a 17-bit address and a byte data bus. The data bus is split into an output value, an output-enable and an input value, so the pad cells can live elsewhere.

All RAM timing is counted in clock cycles. Each minimum is given in nanoseconds as a parameter, together with the clock period. The block derives each phase length as the ceiling of the time over the period, with a floor of one cycle. The request port is valid/ready. A request is taken on a cycle where both `req_valid` and `req_ready` are high. `req_ready` is high only while the sequencer is idle and standby is released, so the requester is back-pressured for the whole RAM cycle and for any bus turnaround that follows it. Read results have no ready. They appear as a one-cycle `rd_valid` pulse that must be consumed when it occurs.

A `standby` input holds the RAM deselected, which is its low-current state. A RAM cycle that is already under way when standby rises runs to completion. No new request is taken until standby falls.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 (standby low), `sram_cs_n`=1, `sram_cs`=0, `sram_we_n`=1, `sram_oe_n`=1, `sram_dq_oe`=0 and `rd_valid`=0.
- R2: A request is accepted only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the sequencer is idle again, so a busy sequencer never shows ready while the RAM is selected.
- R3: A read begins in the cycle after acceptance. For RD_CYC cycles it holds `sram_cs_n`=0, `sram_cs`=1, `sram_oe_n`=0 and `sram_we_n`=1, with the requested address steady on `sram_addr`. RD_CYC is the largest of ceil(70/T), ceil(70/T) and ceil(35/T) for read cycle, access and output-enable access times (9 at T=8 ns).
- R4: `rd_data` takes the value on `sram_dq_in` during the last cycle of the read strobes. `rd_valid` is 1 for exactly one cycle, the first cycle after the strobes end, and is 0 at all other times.
- R5: After a read, both selects stay inactive for TA_CYC = ceil(30/T) cycles (4 at T=8 ns) with `req_ready`=0. The next RAM cycle starts no sooner than TA_CYC+1 cycles after the read strobes end.
- R6: A write begins in the cycle after acceptance. It holds both selects active, `sram_we_n`=0 and `sram_oe_n`=1 for WP_CYC cycles. WP_CYC is the largest of ceil(50/T), ceil(30/T) and ceil(70/T)-1 (8 at T=8 ns). `sram_dq_oe`=1 and `sram_dq_out` equals the request data from the first cycle with `sram_we_n` low.
- R7: The write strobe rises one cycle before the write ends. In that recovery cycle the selects stay active, the address is unchanged, and the write data stays driven. The selects and `sram_dq_oe` then drop together.
- R8: While `standby` is 1, `req_ready` is 0 and both selects stay inactive whatever `req_valid` does. A RAM cycle already started when standby rises completes normally.
- R9: `sram_dq_oe` is never 1 while `sram_oe_n` is 0, nor in the cycle just before `sram_oe_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Hold RAM deselected and refuse requests |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: read data present |
| rd_data | output | 8 | Captured read data |
| sram_addr | output | 17 | RAM address |
| sram_cs_n | output | 1 | RAM select, active low |
| sram_cs | output | 1 | RAM select, active high |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output strobe, active low |
| sram_dq_out | output | 8 | Data toward the RAM |
| sram_dq_oe | output | 1 | Enable for the data output pads |
| sram_dq_in | input | 8 | Data from the RAM |

## Verification
Two pairs of events can land on the same edge. In the first, standby rises in the very cycle a request is offered to an idle sequencer. The bench raises both on one falling edge and judges that the request is not taken and the selects never go active for the whole hold time. In the second, standby rises in the first cycle of a write. The bench then expects the write to finish with its full strobe timing and data, expects no further request to be taken, and reads the byte back after release. Back-to-back requests with a read followed at once by a write also confirm that the turnaround gap is honoured before the bus is driven again.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_READ  = 3'd1,
    PH_TURN  = 3'd2,
    PH_WRITE = 3'd3,
    PH_WREC  = 3'd4
  } phase_e;

  // ceiling of a time over the clock period, never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max_of3(input int unsigned a, input int unsigned b,
                                          input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] last,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = (cnt == last);

  // counts up from zero at the start of each phase and parks on the last value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned RD_CYC = 9,
  parameter int unsigned WP_CYC = 8,
  parameter int unsigned TA_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             phase_done,
  output logic             req_ready,
  output logic             accept,
  output logic             restart,
  output logic [CNT_W-1:0] phase_last,
  output logic             capture,
  output logic             sel,
  output logic             oe_act,
  output logic             we_act,
  output logic             drive
);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TA_CYC - 1);

  phase_e state, nxt;

  assign req_ready = (state == PH_IDLE) && !standby;
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt = state;
    unique case (state)
      PH_IDLE:  if (accept)     nxt = req_write ? PH_WRITE : PH_READ;
      PH_READ:  if (phase_done) nxt = PH_TURN;
      PH_TURN:  if (phase_done) nxt = PH_IDLE;
      PH_WRITE: if (phase_done) nxt = PH_WREC;
      PH_WREC:  if (phase_done) nxt = PH_IDLE;
      default:                  nxt = PH_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      PH_READ:  phase_last = RD_LAST;
      PH_TURN:  phase_last = TA_LAST;
      PH_WRITE: phase_last = WP_LAST;
      default:  phase_last = '0;
    endcase
  end

  assign restart = (nxt != state);
  assign capture = (state == PH_READ) && phase_done;
  assign sel     = (state == PH_READ) || (state == PH_WRITE) || (state == PH_WREC);
  assign oe_act  = (state == PH_READ);
  assign we_act  = (state == PH_WRITE);
  assign drive   = (state == PH_WRITE) || (state == PH_WREC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PH_IDLE;
    else        state <= nxt;
  end

  // R2: a taken request closes the port on the following cycle
  assert_accept_holds_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R8: an idle sequencer stays idle under standby
  assert_standby_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && state == PH_IDLE) |=> (state == PH_IDLE));
endmodule

// File: rtl/sram_ctrl_dpath.sv
`timescale 1ns/1ps
module sram_ctrl_dpath #(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

  // R4: read result is a single-cycle pulse
  assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  // R3: the RAM address only moves when a request is taken
  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(addr_q));
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_NS       = 8,
  parameter int unsigned T_RCYC_NS    = 70,
  parameter int unsigned T_ACC_NS     = 70,
  parameter int unsigned T_OEACC_NS   = 35,
  parameter int unsigned T_WCYC_NS    = 70,
  parameter int unsigned T_WPULSE_NS  = 50,
  parameter int unsigned T_WSETUP_NS  = 30,
  parameter int unsigned T_TURN_NS    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_cs,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int unsigned RD_CYC = max_of3(ns_to_cyc(T_RCYC_NS, CLK_NS),
                                           ns_to_cyc(T_ACC_NS, CLK_NS),
                                           ns_to_cyc(T_OEACC_NS, CLK_NS));
  localparam int unsigned WC_CYC = ns_to_cyc(T_WCYC_NS, CLK_NS);
  localparam int unsigned WP_CYC = max_of3(ns_to_cyc(T_WPULSE_NS, CLK_NS),
                                           ns_to_cyc(T_WSETUP_NS, CLK_NS),
                                           (WC_CYC > 1) ? WC_CYC - 1 : 1);
  localparam int unsigned TA_CYC = ns_to_cyc(T_TURN_NS, CLK_NS);
  localparam int unsigned CNT_W  = $clog2(max_of3(RD_CYC, WP_CYC, TA_CYC) + 1);

  logic             accept, restart, phase_done, capture;
  logic             sel, oe_act, we_act, drive;
  logic [CNT_W-1:0] phase_last;

  sram_ctrl_seq #(
    .CNT_W (CNT_W), .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .TA_CYC(TA_CYC)
  ) u_seq (
    .clk, .rst_n, .standby, .req_valid, .req_write,
    .phase_done, .req_ready, .accept, .restart, .phase_last,
    .capture, .sel, .oe_act, .we_act, .drive
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk, .rst_n, .restart, .last(phase_last), .done(phase_done)
  );

  sram_ctrl_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dpath (
    .clk, .rst_n, .accept, .req_addr, .req_wdata, .capture,
    .dq_in(sram_dq_in), .addr_q(sram_addr), .wdata_q(sram_dq_out),
    .rd_valid, .rd_data
  );

  assign sram_cs_n  = !sel;
  assign sram_cs    = sel;
  assign sram_oe_n  = !oe_act;
  assign sram_we_n  = !we_act;
  assign sram_dq_oe = drive;

  // ---------------- pin-level timing checks ----------------
  localparam int unsigned CW = CNT_W + 1;
  logic [CW-1:0] oe_run, we_run, gap_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_run  <= '0;
      we_run  <= '0;
      gap_run <= CW'(TA_CYC);
    end else begin
      oe_run  <= !sram_oe_n ? oe_run + 1'b1 : '0;
      we_run  <= !sram_we_n ? we_run + 1'b1 : '0;
      if (!sram_oe_n)         gap_run <= '0;
      else if (gap_run != '1) gap_run <= gap_run + 1'b1;
    end
  end

  assert_read_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_oe_n) |-> (oe_run == CW'(RD_CYC)));

  assert_wpulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_run == CW'(WP_CYC)));

  assert_turn_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (gap_run >= CW'(TA_CYC)));

  assert_wrec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sram_we_n) && !sram_cs_n) |-> ($stable(sram_addr) && sram_dq_oe));

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_dq_oe && !$past(sram_dq_oe)));
endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_ctrl;
  localparam int CLK_NS = 8;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC = imax(cyc(70), cyc(35));
  localparam int WP_CYC = imax(imax(cyc(50), cyc(30)), cyc(70) - 1);
  localparam int TA_CYC = cyc(30);

  logic        clk = 1'b0, rst_n = 1'b0, standby = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, sram_cs_n, sram_cs, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  rd_data, sram_dq_out, sram_dq_in;
  logic [16:0] sram_addr;

  sram_ctrl dut (
    .clk, .rst_n, .standby, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rd_valid, .rd_data, .sram_addr, .sram_cs_n, .sram_cs, .sram_we_n, .sram_oe_n,
    .sram_dq_out, .sram_dq_oe, .sram_dq_in
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fold(input logic [16:0] a);
    return a[7:0] ^ a[16:9];
  endfunction
  function automatic logic [7:0] fresh(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // RAM model
  bit          ram_vld [256];
  logic [16:0] ram_tag [256];
  logic [7:0]  ram_dat [256];
  always_comb begin
    if (!sram_cs_n && sram_cs && !sram_oe_n && sram_we_n)
      sram_dq_in = (ram_vld[fold(sram_addr)] && ram_tag[fold(sram_addr)] == sram_addr)
                   ? ram_dat[fold(sram_addr)] : fresh(sram_addr);
    else
      sram_dq_in = 8'hEE;
  end

  // expected contents, kept by the driver
  bit          exp_vld [256];
  logic [16:0] exp_tag [256];
  logic [7:0]  exp_dat [256];

  typedef struct packed { logic wr; logic [16:0] a; logic [7:0] d; } item_t;
  item_t sb[$];

  task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    it.wr = w; it.a = a;
    if (w) begin
      exp_vld[fold(a)] = 1'b1; exp_tag[fold(a)] = a; exp_dat[fold(a)] = d; it.d = d;
    end else begin
      it.d = (exp_vld[fold(a)] && exp_tag[fold(a)] == a) ? exp_dat[fold(a)] : fresh(a);
    end
    sb.push_back(it);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(req_ready == 1'b0, "R2", "ready while busy", int'(req_ready), 0);
  endtask

  // monitor / scoreboard
  bit          in_ep = 0, last_rd = 0;
  int          cs_run, oe_run, we_run, dr_run, gap = 100;
  logic [16:0] ep_addr;
  bit          addr_bad, dat_bad;
  int          stray_rv = 0, turn_bad = 0, r2_bad = 0, cont_bad = 0, sb_bad = 0;

  always @(negedge clk) begin
    item_t it;
    bit act, ended;
    if (rst_n) begin
      act = (sram_cs_n === 1'b0) && (sram_cs === 1'b1);
      ended = 0;
      if (!sram_oe_n && sram_dq_oe) cont_bad++;
      if (act) begin
        if (!in_ep) begin
          if (last_rd) check(gap >= TA_CYC + 1, "R5", "gap after read", gap, TA_CYC + 1);
          in_ep = 1; cs_run = 0; oe_run = 0; we_run = 0; dr_run = 0;
          ep_addr = sram_addr; addr_bad = 0; dat_bad = 0;
        end
        cs_run++;
        if (!sram_oe_n) oe_run++;
        if (!sram_we_n) we_run++;
        if (sram_dq_oe) dr_run++;
        if (sram_addr !== ep_addr) addr_bad = 1;
        if (!sram_we_n) begin
          if (!sram_dq_oe || sb.size() == 0 || sram_dq_out !== sb[0].d) dat_bad = 1;
          ram_vld[fold(sram_addr)] = 1'b1;
          ram_tag[fold(sram_addr)] = sram_addr;
          ram_dat[fold(sram_addr)] = sram_dq_out;
        end
        if (req_ready) r2_bad++;
      end else begin
        if (in_ep) begin
          in_ep = 0; ended = 1; gap = 0;
          if (sb.size() == 0) begin
            check(0, "R3", "strobe cycle with no request", 1, 0);
          end else begin
            it = sb.pop_front();
            check(ep_addr == it.a && !addr_bad, "R3", "address held", int'(ep_addr), int'(it.a));
            if (it.wr) begin
              check(we_run == WP_CYC, "R6", "write pulse cycles", we_run, WP_CYC);
              check(oe_run == 0, "R6", "oe low in write", oe_run, 0);
              check(!dat_bad, "R6", "write data on bus", int'(dat_bad), 0);
              check(cs_run == WP_CYC + 1, "R7", "select cycles in write", cs_run, WP_CYC + 1);
              check(dr_run == WP_CYC + 1, "R7", "drive cycles in write", dr_run, WP_CYC + 1);
              last_rd = 0;
            end else begin
              check(oe_run == RD_CYC && cs_run == RD_CYC, "R3", "read strobe cycles", oe_run, RD_CYC);
              check(we_run == 0 && dr_run == 0, "R9", "no drive in read", dr_run, 0);
              check(rd_valid == 1'b1, "R4", "rd_valid after read", int'(rd_valid), 1);
              check(rd_data == it.d, "R4", "read data", int'(rd_data), int'(it.d));
              last_rd = 1;
            end
          end
        end
        gap++;
        if (last_rd && gap <= TA_CYC && req_ready) turn_bad++;
      end
      if (rd_valid && !ended) stray_rv++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
    check(sram_cs_n == 1'b1 && sram_cs == 1'b0, "R1", "selects idle", int'(sram_cs), 0);
    check(sram_we_n == 1'b1 && sram_oe_n == 1'b1, "R1", "strobes idle", int'(sram_we_n), 1);
    check(sram_dq_oe == 1'b0 && rd_valid == 1'b0, "R1", "bus and rd_valid", int'(sram_dq_oe), 0);

    issue(1, 17'h00012, 8'h3C);
    issue(0, 17'h00012, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    issue(1, 17'h1FFFF, 8'hC3);
    issue(0, 17'h1FFFF, 8'h00);
    issue(1, 17'h00100, 8'h81);
    issue(1, 17'h0A5A5, 8'h7E);
    issue(0, 17'h00100, 8'h00);
    issue(1, 17'h15555, 8'hF0);
    issue(0, 17'h0A5A5, 8'h00);
    issue(0, 17'h15555, 8'h00);
    issue(0, 17'h00777, 8'h00);

    // R8: standby and a request offered on the same edge of an idle sequencer
    repeat (20) @(negedge clk);
    standby = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00042; req_wdata = 8'h11;
    repeat (20) begin
      @(negedge clk); #1;
      if (req_ready || !sram_cs_n || sram_cs) sb_bad++;
    end
    check(sb_bad == 0, "R8", "deselected under standby", sb_bad, 0);
    req_valid = 1'b0;
    @(negedge clk);
    standby = 1'b0;
    issue(0, 17'h00042, 8'h00);

    // R8: standby rising in the first write cycle lets the write finish
    issue(1, 17'h00012, 8'h99);
    standby = 1'b1;
    repeat (20) @(negedge clk);
    #1;
    check(!req_ready && sram_cs_n, "R8", "parked after write", int'(req_ready), 0);
    check(sb.size() == 0, "R8", "write completed under standby", sb.size(), 0);
    standby = 1'b0;
    issue(0, 17'h00012, 8'h00);
    issue(1, 17'h00012, 8'h5D);

    repeat (30) @(negedge clk);
    check(sb.size() == 0, "R3", "all cycles observed", sb.size(), 0);
    check(stray_rv == 0, "R4", "rd_valid outside read end", stray_rv, 0);
    check(turn_bad == 0, "R5", "ready during turnaround", turn_bad, 0);
    check(r2_bad == 0, "R2", "ready while selected", r2_bad, 0);
    check(cont_bad == 0, "R9", "drive with oe low", cont_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule